// File: doc/BRIEF.md
# Power-Up Self-Test Sequencer

This controller runs an ordered series of built-in test steps after power-up or a soft reset. Each step is an external test engine. The controller launches one engine at a time with a one-cycle start pulse and an index. It then waits for that engine's completion strobe, which comes with a pass or fail flag. Steps run from the lowest-level test (index 0) up to the network-level test (the highest index). When every step passes, the controller lights a status LED and gives control to the run-time function.

A failing step leaves the LED dark. It also causes an 8-bit fault code, equal to the failing step's index, to be written through a one-cycle write strobe into non-volatile storage. In single-run mode a failure puts the controller into a broken state. That state lasts a fixed number of seconds, counted by a prescaled timer, and then the whole sequence starts again. In loop-until-error mode the sequence repeats with no end. The non-volatile write test step is left out of every pass after the first. The LED comes on after the first clean pass. On a failure the code also goes to a manufacturing register, and the controller then reruns only the failing step, pulsing a debug trigger once per rerun.

Top module: `st_selftest_seq`

## Requirements
- R1: After reset is released, steps are launched in ascending index order starting at 0. Each launch is a one-cycle `step_start` pulse with the index on `step_idx`. The next launch comes only after a `step_done` for the current step.
- R2: In single-run mode, when the last step passes, `ok_led` and `handoff` go high and stay high, and no further step is launched.
- R3: When `step_done` arrives with `step_fail` high, `err_code` takes the failing index, `nv_we` pulses for exactly one cycle, `ok_led` is low, and the ordered sequence does not continue past that step.
- R4: After a single-run failure, step 0 is launched again exactly CLK_HZ*WAIT_S cycles after the cycle in which `nv_we` is high.
- R5: A later failure replaces the stored code: `err_code` shows the most recent failing index, with one `nv_we` pulse per failure.
- R6: In loop mode the full sequence repeats after each clean pass. Step NVW_STEP (default 2) is launched in the first pass only and is skipped in every later pass.
- R7: In loop mode `ok_led` stays low until the first pass completes and is high from then on while no failure occurs.
- R8: In loop mode a failure drops `ok_led` and pulses `mfg_we` in the same cycle as `nv_we`. After that, only the failing index is launched. `trigger` is high for exactly one cycle with each of those launches and never at another time. `mfg_we` never pulses in single-run mode.
- R9: The mode (`loop_mode`, 1 = loop-until-error) is captured while `rst` is high. Changing it after reset has no effect until the next reset.
- R10: While `rst` is high, `step_start`, `ok_led`, `handoff`, `nv_we`, `mfg_we` and `trigger` are low and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up or soft reset) |
| loop_mode | input | 1 | Mode switch: 1 = loop until error, 0 = single run |
| step_done | input | 1 | Completion strobe from the active test engine |
| step_fail | input | 1 | Fail flag, valid with `step_done` |
| step_start | output | 1 | One-cycle launch pulse for the engine chosen by `step_idx` |
| step_idx | output | CODE_W | Index of the step being launched or run |
| ok_led | output | 1 | Self-test OK indicator |
| handoff | output | 1 | Control given to the run-time function |
| err_code | output | CODE_W | Most recent fault code (failing step index) |
| nv_we | output | 1 | Write strobe to non-volatile storage for `err_code` |
| mfg_we | output | 1 | Write strobe to the manufacturing error register |
| trigger | output | 1 | Debug trigger, one pulse per rerun of the failing step |

## Verification
The bench injects failures at the first step, at a middle step and at the last step. A design that keeps advancing after a fail, or that stores the index of the next step, shows a wrong launch count or a wrong code. It times the broken interval from the storage strobe to the relaunch of step 0, which catches off-by-one errors in the prescaler or the seconds counter. In loop mode it compares the launch order over three passes against the expected pattern, so a design that skips the write test in the first pass or never skips it is caught. It also forces a failure in the second pass to confirm that only the failing step reruns, with a trigger on each rerun. Last, it changes the mode switch after reset and expects no change in behaviour.

// File: rtl/st_selftest_pkg.sv
package st_selftest_pkg;

    typedef enum logic [2:0] {
        SQ_LAUNCH,
        SQ_AWAIT,
        SQ_BROKEN,
        SQ_HANDOFF,
        SQ_RPT_LAUNCH,
        SQ_RPT_AWAIT
    } sq_state_e;

    // Outcome of one completion strobe, decoded once and shared by the blocks.
    typedef struct packed {
        logic pass_step;   // step passed, more steps follow
        logic pass_end;    // step passed and it was the last of the pass
        logic fail;        // step reported a failure
    } sq_event_t;

    // Index that follows cur; an index equal to skip_idx is stepped over
    // when skipping is enabled.
    function automatic int next_index(input int cur, input int skip_idx,
                                      input logic skip_en);
        int r;
        r = cur + 1;
        if (skip_en && r == skip_idx) r = r + 1;
        return r;
    endfunction

    // Index that opens a pass.
    function automatic int first_index(input int skip_idx, input logic skip_en);
        return (skip_en && skip_idx == 0) ? 1 : 0;
    endfunction

endpackage

// File: rtl/st_index_ctl.sv
module st_index_ctl
    import st_selftest_pkg::*;
#(
    parameter int NUM_STEPS = 6,
    parameter int NVW_STEP  = 2,
    parameter int IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             advance,
    input  logic             skip_en,
    input  logic             first_skip,
    output logic [IDX_W-1:0] idx,
    output logic             is_last
);

    int nxt_i;
    int first_i;

    always_comb begin
        nxt_i   = next_index(int'(idx), NVW_STEP, skip_en);
        first_i = first_index(NVW_STEP, first_skip);
        is_last = (nxt_i >= NUM_STEPS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (restart) begin
            idx <= IDX_W'(first_i);
        end else if (advance) begin
            idx <= IDX_W'(nxt_i);
        end
    end

endmodule

// File: rtl/st_wait_timer.sv
module st_wait_timer #(
    parameter int CLK_HZ = 50_000_000,
    parameter int WAIT_S = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);

    localparam int PRE_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam int SEC_W = (WAIT_S > 1) ? $clog2(WAIT_S) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(CLK_HZ - 1);
    localparam logic [SEC_W-1:0] SEC_TOP = SEC_W'(WAIT_S - 1);

    logic [PRE_W-1:0] pre_q;
    logic [SEC_W-1:0] sec_q;
    logic             sec_tick;

    assign sec_tick = (pre_q == PRE_TOP);
    assign expired  = run && sec_tick && (sec_q == SEC_TOP);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q <= '0;
            sec_q <= '0;
        end else if (sec_tick) begin
            pre_q <= '0;
            sec_q <= sec_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/st_fault_log.sv
module st_fault_log #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              to_mfg,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] err_code,
    output logic              nv_we,
    output logic              mfg_we
);

    always_ff @(posedge clk) begin
        if (rst) begin
            err_code <= '0;
            nv_we    <= 1'b0;
            mfg_we   <= 1'b0;
        end else begin
            nv_we  <= capture;
            mfg_we <= capture && to_mfg;
            if (capture) err_code <= code_in;
        end
    end

endmodule

// File: rtl/st_selftest_seq.sv
module st_selftest_seq
    import st_selftest_pkg::*;
#(
    parameter int NUM_STEPS = 6,
    parameter int NVW_STEP  = 2,
    parameter int CODE_W    = 8,
    parameter int CLK_HZ    = 50_000_000,
    parameter int WAIT_S    = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loop_mode,
    input  logic              step_done,
    input  logic              step_fail,
    output logic              step_start,
    output logic [CODE_W-1:0] step_idx,
    output logic              ok_led,
    output logic              handoff,
    output logic [CODE_W-1:0] err_code,
    output logic              nv_we,
    output logic              mfg_we,
    output logic              trigger
);

    localparam int IDX_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS + 1) : 1;

    sq_state_e        state_q;
    logic             loop_q;
    logic             pass1_q;
    logic             ok_q;
    logic             handoff_q;
    logic [IDX_W-1:0] idx;
    logic             is_last;
    logic             wait_over;
    sq_event_t        ev;
    logic             in_await;

    assign in_await     = (state_q == SQ_AWAIT);
    assign ev.fail      = in_await && step_done && step_fail;
    assign ev.pass_step = in_await && step_done && !step_fail && !is_last;
    assign ev.pass_end  = in_await && step_done && !step_fail && is_last;

    st_index_ctl #(
        .NUM_STEPS(NUM_STEPS),
        .NVW_STEP (NVW_STEP),
        .IDX_W    (IDX_W)
    ) u_index (
        .clk       (clk),
        .rst       (rst),
        .restart   (ev.pass_end || wait_over),
        .advance   (ev.pass_step),
        .skip_en   (loop_q && pass1_q),
        .first_skip(loop_q && (pass1_q || ev.pass_end)),
        .idx       (idx),
        .is_last   (is_last)
    );

    st_wait_timer #(
        .CLK_HZ(CLK_HZ),
        .WAIT_S(WAIT_S)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state_q == SQ_BROKEN),
        .expired(wait_over)
    );

    st_fault_log #(
        .CODE_W(CODE_W)
    ) u_log (
        .clk     (clk),
        .rst     (rst),
        .capture (ev.fail),
        .to_mfg  (loop_q),
        .code_in (step_idx),
        .err_code(err_code),
        .nv_we   (nv_we),
        .mfg_we  (mfg_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_LAUNCH;
            loop_q    <= loop_mode;
            pass1_q   <= 1'b0;
            ok_q      <= 1'b0;
            handoff_q <= 1'b0;
        end else begin
            case (state_q)
                SQ_LAUNCH: state_q <= SQ_AWAIT;
                SQ_AWAIT: begin
                    if (ev.fail) begin
                        ok_q    <= 1'b0;
                        state_q <= loop_q ? SQ_RPT_LAUNCH : SQ_BROKEN;
                    end else if (ev.pass_end) begin
                        ok_q <= 1'b1;
                        if (loop_q) begin
                            pass1_q <= 1'b1;
                            state_q <= SQ_LAUNCH;
                        end else begin
                            handoff_q <= 1'b1;
                            state_q   <= SQ_HANDOFF;
                        end
                    end else if (ev.pass_step) begin
                        state_q <= SQ_LAUNCH;
                    end
                end
                SQ_BROKEN:     if (wait_over) state_q <= SQ_LAUNCH;
                SQ_HANDOFF:    state_q <= SQ_HANDOFF;
                SQ_RPT_LAUNCH: state_q <= SQ_RPT_AWAIT;
                SQ_RPT_AWAIT:  if (step_done) state_q <= SQ_RPT_LAUNCH;
                default:       state_q <= SQ_LAUNCH;
            endcase
        end
    end

    assign step_start = !rst && (state_q == SQ_LAUNCH || state_q == SQ_RPT_LAUNCH);
    assign trigger    = !rst && (state_q == SQ_RPT_LAUNCH);
    assign step_idx   = CODE_W'(idx);
    assign ok_led     = ok_q;
    assign handoff    = handoff_q;

endmodule

// File: rtl/st_selftest_chk.sv
module st_selftest_chk #(
    parameter int NUM_STEPS = 6,
    parameter int CODE_W    = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              step_start,
    input logic [CODE_W-1:0] step_idx,
    input logic              ok_led,
    input logic              handoff,
    input logic              nv_we,
    input logic              mfg_we,
    input logic              trigger
);

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        step_start |-> (step_idx < CODE_W'(NUM_STEPS)));                  // R1

    AST_HANDOFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
        handoff |=> (handoff && ok_led && !step_start));                  // R2

    AST_NVWE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        nv_we |=> !nv_we);                                                // R3

    AST_LED_DARK_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
        nv_we |-> !ok_led);                                               // R3

    AST_MFG_WITH_NV: assert property (@(posedge clk) disable iff (rst)
        mfg_we |-> nv_we);                                                // R8

    AST_TRIG_WITH_START: assert property (@(posedge clk) disable iff (rst)
        trigger |-> step_start);                                          // R8

    AST_TRIG_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        trigger |=> !trigger);                                            // R8

endmodule

bind st_selftest_seq st_selftest_chk #(
    .NUM_STEPS(NUM_STEPS),
    .CODE_W   (CODE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .step_start(step_start),
    .step_idx  (step_idx),
    .ok_led    (ok_led),
    .handoff   (handoff),
    .nv_we     (nv_we),
    .mfg_we    (mfg_we),
    .trigger   (trigger)
);

// File: tb/test_st_selftest_seq.sv
module test_st_selftest_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NSTEP      = 6;
    localparam int SKIP_STEP  = 2;
    localparam int HZ         = 4;
    localparam int SECS       = 15;
    localparam int WAIT_CYC   = HZ * SECS;
    localparam int WDOG       = 20000;

    // table: fail index in first run (-1 none), expected launches, expected code
    localparam int TBL_N = 5;
    localparam int TBL [TBL_N][3] = '{
        '{-1, 6, 0},
        '{ 0, 1, 0},
        '{ 2, 3, 2},
        '{ 5, 6, 5},
        '{ 3, 4, 3}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       loop_mode = 1'b0;
    logic       step_done;
    logic       step_fail;
    logic       step_start;
    logic [7:0] step_idx;
    logic       ok_led;
    logic       handoff;
    logic [7:0] err_code;
    logic       nv_we;
    logic       mfg_we;
    logic       trigger;

    int checks = 0;
    int errors = 0;
    int fail_a = -1;
    int fail_b = -1;

    int cyc = 0;
    int pend, cnt, cur, runs0, log_n, nv_cnt, mfg_cnt, nv_cyc, restart_cyc;
    int trig_cnt, trig_bad, after_bad, ok_early;
    int log_idx [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    st_selftest_seq #(
        .NUM_STEPS(NSTEP),
        .NVW_STEP (SKIP_STEP),
        .CODE_W   (8),
        .CLK_HZ   (HZ),
        .WAIT_S   (SECS)
    ) i_st_selftest_seq (
        .clk(clk), .rst(rst), .loop_mode(loop_mode),
        .step_done(step_done), .step_fail(step_fail),
        .step_start(step_start), .step_idx(step_idx),
        .ok_led(ok_led), .handoff(handoff), .err_code(err_code),
        .nv_we(nv_we), .mfg_we(mfg_we), .trigger(trigger)
    );

    // engine stub and monitor, all at the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst) begin
            step_done = 1'b0; step_fail = 1'b0; pend = 0; cnt = 0; runs0 = 0;
            log_n = 0; nv_cnt = 0; mfg_cnt = 0; nv_cyc = -1; restart_cyc = -1;
            trig_cnt = 0; trig_bad = 0; after_bad = 0; ok_early = 0;
        end else begin
            step_done = 1'b0;
            step_fail = 1'b0;
            if (pend != 0) begin
                if (cnt == 0) begin
                    step_done = 1'b1;
                    step_fail = ((cur == fail_a) && runs0 == 1) ||
                                ((cur == fail_b) && runs0 >= 2);
                    pend = 0;
                end else begin
                    cnt = cnt - 1;
                end
            end
            if (nv_we) begin
                nv_cnt = nv_cnt + 1;
                nv_cyc = cyc;
            end
            if (mfg_we) mfg_cnt = mfg_cnt + 1;
            if (trigger) begin
                trig_cnt = trig_cnt + 1;
                if (!step_start) trig_bad = trig_bad + 1;
            end
            if (step_start) begin
                cur = int'(step_idx);
                if (cur == 0 && !trigger) runs0 = runs0 + 1;
                if (log_n < 64) log_idx[log_n] = cur;
                log_n = log_n + 1;
                if (nv_cnt > 0 && restart_cyc < 0) restart_cyc = cyc;
                if (nv_cnt > 0 && cur != int'(err_code)) after_bad = after_bad + 1;
                if (nv_cnt > 0 && !trigger && mfg_cnt > 0) trig_bad = trig_bad + 1;
                pend = 1;
                cnt = 2;
            end
            if (ok_led && log_n < NSTEP) ok_early = 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_run(input logic mode, input bit check_rst);
        @(negedge clk);
        rst = 1'b1;
        loop_mode = mode;
        repeat (3) @(negedge clk);
        if (check_rst) begin
            // R10: quiet outputs during reset
            chk("R10 step_start", int'(step_start), 0);
            chk("R10 ok_led", int'(ok_led), 0);
            chk("R10 handoff", int'(handoff), 0);
            chk("R10 nv_we/mfg_we/trigger", int'(nv_we) + int'(mfg_we) + int'(trigger), 0);
            chk("R10 err_code", int'(err_code), 0);
        end
        rst = 1'b0;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog actual=%0d expected=done", WDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // table walk: single-run mode, one failure point per entry (R1, R2, R3)
        for (int t = 0; t < TBL_N; t++) begin
            fail_a = TBL[t][0];
            fail_b = -1;
            start_run(1'b0, t == 0);
            repeat (45) @(negedge clk);
            chk("R1 launch count", log_n, TBL[t][1]);
            begin
                int order_bad = 0;
                for (int k = 0; k < TBL[t][1] && k < 64; k++)
                    if (log_idx[k] != k) order_bad++;
                chk("R1 ascending order", order_bad, 0);
            end
            if (TBL[t][0] < 0) begin
                chk("R2 ok_led", int'(ok_led), 1);
                chk("R2 handoff", int'(handoff), 1);
                chk("R3 no nv write on pass", nv_cnt, 0);
            end else begin
                chk("R3 err_code", int'(err_code), TBL[t][2]);
                chk("R3 nv_we pulses", nv_cnt, 1);
                chk("R3 ok_led dark", int'(ok_led), 0);
                chk("R3 no handoff", int'(handoff), 0);
                chk("R8 no mfg write in single-run", mfg_cnt, 0);
            end
        end

        // R4: broken interval then full rerun that passes
        fail_a = 4; fail_b = -1;
        start_run(1'b0, 1'b0);
        repeat (130) @(negedge clk);
        chk("R4 relaunch delay", restart_cyc - nv_cyc, WAIT_CYC);
        chk("R4 relaunch index", log_idx[5], 0);
        chk("R4 handoff after rerun", int'(handoff), 1);
        chk("R4 ok_led after rerun", int'(ok_led), 1);
        chk("R4 code kept", int'(err_code), 4);

        // R5: second failure overwrites the code
        fail_a = 3; fail_b = 1;
        start_run(1'b0, 1'b0);
        repeat (120) @(negedge clk);
        chk("R5 nv_we count", nv_cnt, 2);
        chk("R5 newest code", int'(err_code), 1);

        // R6, R7: loop mode, no failures
        fail_a = -1; fail_b = -1;
        start_run(1'b1, 1'b0);
        repeat (80) @(negedge clk);
        begin
            int exp_seq [16];
            int n = 0;
            int seq_bad = 0;
            for (int p = 0; p < 4 && n < 16; p++)
                for (int s = 0; s < NSTEP && n < 16; s++)
                    if (!(p > 0 && s == SKIP_STEP)) begin
                        exp_seq[n] = s;
                        n++;
                    end
            for (int k = 0; k < 16; k++)
                if (log_idx[k] != exp_seq[k]) seq_bad++;
            chk("R6 launch pattern over passes", seq_bad, 0);
        end
        chk("R6 keeps looping", int'(log_n >= 16), 1);
        chk("R7 led not early", ok_early, 0);
        chk("R7 led on", int'(ok_led), 1);
        chk("R7 no handoff in loop", int'(handoff), 0);

        // R8: loop mode, failure at step 3 on the second pass
        fail_a = -1; fail_b = 3;
        start_run(1'b1, 1'b0);
        repeat (80) @(negedge clk);
        chk("R8 nv_we count", nv_cnt, 1);
        chk("R8 mfg_we count", mfg_cnt, 1);
        chk("R8 code", int'(err_code), 3);
        chk("R8 led off", int'(ok_led), 0);
        chk("R8 only failing step reruns", after_bad, 0);
        chk("R8 trigger tied to reruns", trig_bad, 0);
        chk("R8 trigger repeats", int'(trig_cnt >= 3), 1);

        // R9: mode switch moved after reset is ignored
        fail_a = -1; fail_b = -1;
        start_run(1'b0, 1'b0);
        @(negedge clk);
        loop_mode = 1'b1;
        repeat (45) @(negedge clk);
        chk("R9 single-run kept: handoff", int'(handoff), 1);
        chk("R9 single-run kept: launches", log_n, NSTEP);
        loop_mode = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule